// File: doc/BRIEF.md
# 66-bit block to XGMII lane decoder

This block turns each received 66-bit block back into the eight-lane, 64-bit data and 8-bit control form of XGMII. The receive path ahead of it has already found the block boundary and removed the scrambling. Each block carries a 2-bit header in bits [1:0]. A data header passes the 64 payload bits straight to the lanes with every control bit low. A control header makes the block decode through its 8-bit type field in bits [9:2], and the 56 payload bits above it rebuild idle, error, start and terminate characters in the right lanes.

Bad headers, unknown type values and undefined 7-bit control codes never reach the lanes as data. They come out as the XGMII error character. The lane outputs are registered, so every block appears exactly one clock after it is presented. One block is accepted on every clock.

Top module: `dec66_rx`

## Requirements
- R1: While reset is asserted, every lane shows idle 0x07 and all eight control bits are 1.
- R2: The lanes decoded from a block are visible on the outputs one clock after that block is sampled, and a new block is accepted on every clock.
- R3: Header 2'b01 is a data block: lane k carries blk_in[2+8k +: 8] and the control bits are 0x00.
- R4: Header 2'b00 or 2'b11 puts error 0xFE on all lanes, with the control bits at 0xFF.
- R5: Header 2'b10 with type 0x1E is an all-control block: lane k takes the 7-bit code at blk_in[10+7k +: 7], code 0x00 becomes idle 0x07, code 0x1E becomes error 0xFE, and the control bits are 0xFF.
- R6: Any 7-bit control code other than 0x00 and 0x1E, in any lane that carries one, decodes to error 0xFE.
- R7: Type 0x78 puts start 0xFB on lane 0. Lane k (1..7) carries blk_in[10+8(k-1) +: 8], and the control bits are 0x01.
- R8: Type 0x33 decodes lanes 0..3 from the codes at blk_in[10+7k +: 7] and puts start 0xFB on lane 4. Lanes 5..7 carry blk_in[42+8(k-5) +: 8], and the control bits are 0x1F.
- R9: Types 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF place terminate 0xFD in lane t = 0..7. Lanes below t carry data blk_in[10+8i +: 8] with their control bits at 0. Lanes above t decode their codes at blk_in[10+7k +: 7]. The control bits are 1 for lane t and for every lane above it.
- R10: Under header 2'b10, any type value not named in R5, R7, R8 or R9 puts error 0xFE on all lanes, with the control bits at 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one block is sampled per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_in | input | 66 | Aligned, descrambled block: header [1:0], type [9:2], payload [65:10] |
| xd_out | output | 64 | Decoded lane characters, lane k in bits [8k+7:8k] |
| xc_out | output | 8 | Per-lane control flags, bit k for lane k |

## Verification
The bench builds the block with its default eight-lane parameter, the only value the 66-bit layout allows, so the elaboration guard is never tripped. With eight lanes, the bench sweeps every terminate position from lane 0 to lane 7. This covers the edge cases where no data lane comes before the terminate and where no control lane comes after it. The bench also sends undefined codes and types into lanes that the common data and idle traffic never sets to error.

// File: rtl/dec66_pkg.sv
package dec66_pkg;

   localparam int unsigned HDR_W  = 2;
   localparam int unsigned TYPE_W = 8;
   localparam int unsigned CHAR_W = 8;
   localparam int unsigned CODE_W = 7;

   localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
   localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

   localparam logic [TYPE_W-1:0] TY_ALLCTL = 8'h1E;
   localparam logic [TYPE_W-1:0] TY_SOF0   = 8'h78;
   localparam logic [TYPE_W-1:0] TY_SOF4   = 8'h33;

   localparam logic [CHAR_W-1:0] CH_IDLE  = 8'h07;
   localparam logic [CHAR_W-1:0] CH_START = 8'hFB;
   localparam logic [CHAR_W-1:0] CH_TERM  = 8'hFD;
   localparam logic [CHAR_W-1:0] CH_ERROR = 8'hFE;

   localparam logic [CODE_W-1:0] CD_IDLE  = 7'h00;
   localparam logic [CODE_W-1:0] CD_ERROR = 7'h1E;

   typedef enum logic [2:0] {
      BK_DATA,
      BK_ALLCTL,
      BK_SOF0,
      BK_SOF4,
      BK_EOF,
      BK_BAD
   } blk_kind_e;

   function automatic logic [CHAR_W-1:0] code_to_char(input logic [CODE_W-1:0] cd);
      case (cd)
         CD_IDLE:  code_to_char = CH_IDLE;
         CD_ERROR: code_to_char = CH_ERROR;
         default:  code_to_char = CH_ERROR;
      endcase
   endfunction

endpackage

// File: rtl/dec66_classify.sv
module dec66_classify
   import dec66_pkg::*;
(
   input  logic [HDR_W-1:0]  hdr,
   input  logic [TYPE_W-1:0] btype,
   output blk_kind_e         kind,
   output logic [2:0]        eof_lane
);

   always_comb begin
      kind     = BK_BAD;
      eof_lane = 3'd0;
      if (hdr == HDR_DATA) begin
         kind = BK_DATA;
      end else if (hdr == HDR_CTRL) begin
         case (btype)
            TY_ALLCTL: kind = BK_ALLCTL;
            TY_SOF0:   kind = BK_SOF0;
            TY_SOF4:   kind = BK_SOF4;
            8'h87: begin kind = BK_EOF; eof_lane = 3'd0; end
            8'h99: begin kind = BK_EOF; eof_lane = 3'd1; end
            8'hAA: begin kind = BK_EOF; eof_lane = 3'd2; end
            8'hB4: begin kind = BK_EOF; eof_lane = 3'd3; end
            8'hCC: begin kind = BK_EOF; eof_lane = 3'd4; end
            8'hD2: begin kind = BK_EOF; eof_lane = 3'd5; end
            8'hE1: begin kind = BK_EOF; eof_lane = 3'd6; end
            8'hFF: begin kind = BK_EOF; eof_lane = 3'd7; end
            default: kind = BK_BAD;
         endcase
      end
   end

endmodule

// File: rtl/dec66_lane.sv
module dec66_lane
   import dec66_pkg::*;
#(
   parameter int unsigned LANE_IDX = 0
)(
   input  blk_kind_e         kind,
   input  logic [2:0]        eof_lane,
   input  logic [CHAR_W-1:0] raw_byte,
   input  logic [CHAR_W-1:0] pay_byte,
   input  logic [CHAR_W-1:0] sof0_byte,
   input  logic [CHAR_W-1:0] sof4_byte,
   input  logic [CODE_W-1:0] code,
   output logic [CHAR_W-1:0] ch,
   output logic              ct
);

   localparam logic [2:0] LIDX = 3'(LANE_IDX);

   always_comb begin
      ch = CH_ERROR;
      ct = 1'b1;
      case (kind)
         BK_DATA: begin
            ch = raw_byte;
            ct = 1'b0;
         end
         BK_ALLCTL: begin
            ch = code_to_char(code);
         end
         BK_SOF0: begin
            if (LIDX == 3'd0) begin
               ch = CH_START;
            end else begin
               ch = sof0_byte;
               ct = 1'b0;
            end
         end
         BK_SOF4: begin
            if (LIDX < 3'd4) begin
               ch = code_to_char(code);
            end else if (LIDX == 3'd4) begin
               ch = CH_START;
            end else begin
               ch = sof4_byte;
               ct = 1'b0;
            end
         end
         BK_EOF: begin
            if (LIDX < eof_lane) begin
               ch = pay_byte;
               ct = 1'b0;
            end else if (LIDX == eof_lane) begin
               ch = CH_TERM;
            end else begin
               ch = code_to_char(code);
            end
         end
         default: begin
            ch = CH_ERROR;
            ct = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/dec66_rx.sv
module dec66_rx
   import dec66_pkg::*;
#(
   parameter int unsigned LANES = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [HDR_W+LANES*8-1:0]  blk_in,
   output logic [LANES*8-1:0]        xd_out,
   output logic [LANES-1:0]          xc_out
);

   localparam int unsigned BLK_W   = HDR_W + LANES*CHAR_W;
   localparam int unsigned PAY_LSB = HDR_W + TYPE_W;
   localparam int unsigned SOF4_LSB = PAY_LSB + 4*CODE_W + 4;

   if (LANES != 8) begin : g_bad_lanes
      $error("dec66_rx: the 66-bit block layout needs LANES == 8");
   end
   if (BLK_W != 66) begin : g_bad_width
      $error("dec66_rx: block width must be 66 bits");
   end

   blk_kind_e  kind;
   logic [2:0] eof_lane;

   dec66_classify i_classify (
      .hdr      (blk_in[HDR_W-1:0]),
      .btype    (blk_in[PAY_LSB-1:HDR_W]),
      .kind     (kind),
      .eof_lane (eof_lane)
   );

   logic [LANES*CHAR_W-1:0] d_nxt;
   logic [LANES-1:0]        c_nxt;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [CHAR_W-1:0] pay_b, sof0_b, sof4_b;

      if (k <= 6) begin : g_pay
         assign pay_b = blk_in[PAY_LSB + CHAR_W*k +: CHAR_W];
      end else begin : g_nopay
         assign pay_b = '0;
      end

      if (k >= 1) begin : g_sof0
         assign sof0_b = blk_in[PAY_LSB + CHAR_W*(k-1) +: CHAR_W];
      end else begin : g_nosof0
         assign sof0_b = '0;
      end

      if (k >= 5) begin : g_sof4
         assign sof4_b = blk_in[SOF4_LSB + CHAR_W*(k-5) +: CHAR_W];
      end else begin : g_nosof4
         assign sof4_b = '0;
      end

      dec66_lane #(.LANE_IDX(k)) i_lane (
         .kind      (kind),
         .eof_lane  (eof_lane),
         .raw_byte  (blk_in[HDR_W + CHAR_W*k +: CHAR_W]),
         .pay_byte  (pay_b),
         .sof0_byte (sof0_b),
         .sof4_byte (sof4_b),
         .code      (blk_in[PAY_LSB + CODE_W*k +: CODE_W]),
         .ch        (d_nxt[CHAR_W*k +: CHAR_W]),
         .ct        (c_nxt[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xd_out <= {LANES{CH_IDLE}};
         xc_out <= '1;
      end else begin
         xd_out <= d_nxt;
         xc_out <= c_nxt;
      end
   end

endmodule

// File: rtl/dec66_rx_chk.sv
module dec66_rx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [65:0] blk_in,
   input logic [63:0] xd_out,
   input logic [7:0]  xc_out
);

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R3
   data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(blk_in[1:0]) == 2'b01) |->
         (xc_out == 8'h00 && xd_out == $past(blk_in[65:2])));

   // R4
   bad_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && ($past(blk_in[1:0]) == 2'b00 || $past(blk_in[1:0]) == 2'b11)) |->
         (xc_out == 8'hFF && xd_out == {8{8'hFE}}));

   // R5
   all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(blk_in[9:0]) == {8'h1E, 2'b10} && $past(blk_in[65:10]) == 56'd0) |->
         (xc_out == 8'hFF && xd_out == {8{8'h07}}));

   // R7
   sof_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(blk_in[9:0]) == {8'h78, 2'b10}) |->
         (xc_out == 8'h01 && xd_out[7:0] == 8'hFB));

   // R9
   eof_lane7_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(blk_in[9:0]) == {8'hFF, 2'b10}) |->
         (xc_out == 8'h80 && xd_out[63:56] == 8'hFD));

endmodule

bind dec66_rx dec66_rx_chk i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .blk_in (blk_in),
   .xd_out (xd_out),
   .xc_out (xc_out)
);

// File: tb/test_dec66_rx.sv
module test_dec66_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [65:0] blk_in = '0;
   logic [63:0] xd_out;
   logic [7:0]  xc_out;

   always #5 clk = ~clk;

   dec66_rx i_dec66_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .blk_in (blk_in),
      .xd_out (xd_out),
      .xc_out (xc_out)
   );

   typedef struct {
      logic [63:0] d;
      logic [7:0]  c;
      int          tag;
      string       req;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: the block pushed after edge N is visible after edge N+1
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].tag == cyc - 1) begin
         exp_t e;
         e = sb.pop_front();
         n_chk++;
         if (xd_out !== e.d || xc_out !== e.c) begin
            n_fail++;
            $display("FAIL %s: got d=%h c=%h, expected d=%h c=%h",
                     e.req, xd_out, xc_out, e.d, e.c);
         end
      end
   end

   function automatic logic [7:0] ref_char(input logic [6:0] cd);
      if (cd == 7'h00) return 8'h07;
      return 8'hFE;
   endfunction

   task automatic drive(input logic [65:0] b, input logic [63:0] d,
                        input logic [7:0] c, input string req);
      exp_t e;
      @(posedge clk);
      #1;
      blk_in = b;
      e.d = d; e.c = c; e.tag = cyc; e.req = req;
      sb.push_back(e);
   endtask

   task automatic send_data(input logic [63:0] v);
      drive({v, 2'b01}, v, 8'h00, "R3 R2 data block");
   endtask

   task automatic send_bad(input logic [1:0] h, input logic [63:0] v);
      drive({v, h}, {8{8'hFE}}, 8'hFF, "R4 bad header");
   endtask

   task automatic send_allctl(input logic [6:0] cd [8], input string req);
      logic [55:0] pay = '0;
      logic [63:0] d;
      for (int k = 0; k < 8; k++) begin
         pay[7*k +: 7] = cd[k];
         d[8*k +: 8]   = ref_char(cd[k]);
      end
      drive({pay, 8'h1E, 2'b10}, d, 8'hFF, req);
   endtask

   task automatic send_sof0(input logic [55:0] dat);
      drive({dat, 8'h78, 2'b10}, {dat, 8'hFB}, 8'h01, "R7 start lane 0");
   endtask

   task automatic send_sof4(input logic [6:0] cd [4], input logic [23:0] dat);
      logic [55:0] pay = '0;
      logic [63:0] d;
      for (int k = 0; k < 4; k++) begin
         pay[7*k +: 7] = cd[k];
         d[8*k +: 8]   = ref_char(cd[k]);
      end
      pay[55:32] = dat;
      d[39:32]   = 8'hFB;
      d[63:40]   = dat;
      drive({pay, 8'h33, 2'b10}, d, 8'h1F, "R8 start lane 4");
   endtask

   task automatic send_eof(input int t, input logic [55:0] dat, input logic [6:0] tail_cd);
      logic [7:0]  ty_tab [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
      logic [55:0] pay = '0;
      logic [63:0] d;
      logic [7:0]  c = '0;
      for (int k = 0; k < 8; k++) begin
         if (k < t) begin
            pay[8*k +: 8] = dat[8*k +: 8];
            d[8*k +: 8]   = dat[8*k +: 8];
         end else if (k == t) begin
            d[8*k +: 8] = 8'hFD;
            c[k] = 1'b1;
         end else begin
            pay[7*k +: 7] = tail_cd;
            d[8*k +: 8]   = ref_char(tail_cd);
            c[k] = 1'b1;
         end
      end
      drive({pay, ty_tab[t], 2'b10}, d, c, $sformatf("R9 terminate lane %0d", t));
   endtask

   task automatic send_unknown(input logic [7:0] ty, input logic [55:0] pay);
      drive({pay, ty, 2'b10}, {8{8'hFE}}, 8'hFF, "R10 unknown type");
   endtask

   initial begin
      logic [6:0] cd8 [8];
      logic [6:0] cd4 [4];
      repeat (3) @(posedge clk);
      #1;
      n_chk++;
      if (xd_out !== {8{8'h07}} || xc_out !== 8'hFF) begin
         n_fail++;
         $display("FAIL R1 reset: got d=%h c=%h, expected d=%h c=%h",
                  xd_out, xc_out, {8{8'h07}}, 8'hFF);
      end
      @(negedge clk);
      rst_n = 1'b1;

      send_data(64'h0123_4567_89AB_CDEF);
      send_data(64'hFFFF_FFFF_FFFF_FFFF);
      send_data(64'hFB07_FDFE_0000_9C55);
      send_bad(2'b00, 64'h0123_4567_89AB_CDEF);
      send_bad(2'b11, 64'h0);

      cd8 = '{default: 7'h00};
      send_allctl(cd8, "R5 all idle");
      cd8 = '{7'h00, 7'h1E, 7'h00, 7'h1E, 7'h1E, 7'h00, 7'h00, 7'h1E};
      send_allctl(cd8, "R5 idle and error mix");
      cd8 = '{7'h2D, 7'h00, 7'h7F, 7'h00, 7'h33, 7'h00, 7'h01, 7'h4B};
      send_allctl(cd8, "R6 undefined codes");

      send_sof0(56'hD5_5555_5555_5555);
      send_sof0(56'h12_3456_789A_BCDE);
      cd4 = '{7'h00, 7'h00, 7'h00, 7'h00};
      send_sof4(cd4, 24'h55_55D5);
      cd4 = '{7'h00, 7'h1E, 7'h66, 7'h00};
      send_sof4(cd4, 24'hA1_B2C3);

      for (int t = 0; t < 8; t++)
         send_eof(t, 56'h77_6655_4433_2211, 7'h00);
      send_eof(3, 56'hDE_ADBE_EF01_0203, 7'h1E);
      send_eof(2, 56'h0, 7'h55);

      send_unknown(8'h2D, 56'h0);
      send_unknown(8'h00, 56'h0);
      send_unknown(8'h4B, 56'h1234);
      send_data(64'hCAFE_F00D_DEAD_BEEF);

      repeat (4) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule